// File: doc/BRIEF.md
# Task Address Set Differential Unit

This block watches a stream of memory accesses that start and stop pulses split into task instances. While an instance is open it keeps each distinct address the task touches, in the order the task first touched it. A later access to a stored address changes nothing, whether it is a read or a write. The stored list of the instance that closed before is kept alongside.

When an instance closes and an older list exists, the block subtracts the older list from the new one entry by entry. It sends the signed results out one per cycle under a valid/ready handshake, with a marker on the final element. When the stream ends, or at once if there is nothing to send, the new list replaces the older one. A following stage, such as a predictor, can use these differential vectors to spot instances whose address patterns repeat. Both stored lists can be read at any index through a combinational read port.

Top module: `tdiff_unit`

## Requirements
- R1: A start pulse opens an instance only while no instance is open and no vector is streaming, and it empties the current list. A stop pulse closes an open instance. An access on the same cycle as the opening start pulse, or on the same cycle as the closing stop pulse, belongs to that instance. Accesses at any other time while no instance is open are ignored.
- R2: An address is added to the current list only on its first access within the instance. Repeat accesses add nothing. Reads and writes (`acc_write` 1 = write, 0 = read) are treated alike, so `cur_count` grows by at most one per cycle.
- R3: List entries keep first-access order: index 0 holds the earliest new address, and `cur_rd_addr`/`prev_rd_addr` return entry `rd_idx` of each list.
- R4: A list holds at most DEPTH entries. A new address that arrives when the list is full is dropped and sets `overflow`. The flag stays set until the next instance opens, and it is clear at that opening.
- R5: When an instance closes, its list becomes the previous list: right away if no vector is sent, or after the last element is accepted. The first instance after reset produces no vector.
- R6: Element i of the vector equals current entry i minus previous entry i. Both addresses are taken as unsigned, and the result is an AW+1 bit two's complement value, so zero and negative results are exact.
- R7: The vector covers min(current length, previous length) elements, and it is empty if that minimum is zero. At each close that has a previous list, `len_mismatch` is set if the two lengths differ and cleared if they are equal. It holds its value until the next such close.
- R8: The first element is valid on the cycle after the closing edge. One element is sent per accepted cycle, and `diff_last` is high only on the final one. While `diff_ready` is low, the element and its marker hold steady.
- R9: While a vector streams, start pulses, stop pulses and accesses are ignored, and the current list does not change.
- R10: After reset, both counts are zero, and `diff_valid`, `overflow` and `len_mismatch` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| task_start | input | 1 | Start-of-instance pulse |
| task_stop | input | 1 | End-of-instance pulse |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | Access kind, 1 = write, 0 = read |
| acc_addr | input | AW | Access address |
| diff_ready | input | 1 | Consumer accepts the current element |
| diff_valid | output | 1 | Differential element valid |
| diff_data | output | AW+1 | Signed differential element |
| diff_last | output | 1 | Final element of the vector |
| cur_count | output | $clog2(DEPTH+1) | Entries in the current list |
| prev_count | output | $clog2(DEPTH+1) | Entries in the previous list |
| overflow | output | 1 | New address dropped for lack of room |
| len_mismatch | output | 1 | Lengths differed at the last compared close |
| rd_idx | input | $clog2(DEPTH) | List read index |
| cur_rd_addr | output | AW | Current list entry at rd_idx |
| prev_rd_addr | output | AW | Previous list entry at rd_idx |

## Verification
An access can arrive on the same cycle as the closing stop pulse. In that cycle the list is updated and the vector length and mismatch flag are decided, and both must see the newly added address. The bench places an access, sometimes new and sometimes a repeat, on the stop cycle of about a third of the instances. It also puts the first access on the start cycle of every other instance. It then compares the streamed length, every element, the mismatch flag and the previous list, as read afterwards, with a model that adds the access before closing.

// File: rtl/tdiff_unit.sv
module tdiff_unit #(
  parameter int AW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         task_start,
  input  logic                         task_stop,
  input  logic                         acc_valid,
  input  logic                         acc_write,
  input  logic [AW-1:0]                acc_addr,
  input  logic                         diff_ready,
  output logic                         diff_valid,
  output logic [AW:0]                  diff_data,
  output logic                         diff_last,
  output logic [$clog2(DEPTH+1)-1:0]   cur_count,
  output logic [$clog2(DEPTH+1)-1:0]   prev_count,
  output logic                         overflow,
  output logic                         len_mismatch,
  input  logic [$clog2(DEPTH)-1:0]     rd_idx,
  output logic [AW-1:0]                cur_rd_addr,
  output logic [AW-1:0]                prev_rd_addr
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int IW = $clog2(DEPTH);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] ONE  = CW'(1);

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_DRAIN} st_t;
  st_t st;

  logic [AW-1:0] cur_q  [DEPTH];
  logic [AW-1:0] prev_q [DEPTH];
  logic [CW-1:0] cur_cnt, prev_cnt, drain_len, ptr, base_cnt, next_cnt, shorter;
  logic have_prev, ovf_q, mism_q;
  logic open_i, take, hit, ins, drop, close_i, go_drain, fin, copy;

  assign open_i   = (st == S_IDLE) && task_start;
  assign close_i  = (st == S_ACT) && task_stop;
  assign take     = acc_valid && ((st == S_ACT) || open_i);
  assign base_cnt = open_i ? '0 : cur_cnt;

  always_comb begin
    hit = 1'b0;
    for (int j = 0; j < DEPTH; j++)
      if (!open_i && (CW'(j) < cur_cnt) && (cur_q[j] == acc_addr)) hit = 1'b1;
  end

  assign ins      = take && !hit && (base_cnt != FULL);
  assign drop     = take && !hit && (base_cnt == FULL);
  assign next_cnt = base_cnt + CW'(ins);
  assign shorter  = (next_cnt < prev_cnt) ? next_cnt : prev_cnt;
  assign go_drain = close_i && have_prev && (shorter != '0);
  assign fin      = (st == S_DRAIN) && diff_ready && (ptr == drain_len - ONE);
  assign copy     = (close_i && !go_drain) || fin;

  for (genvar j = 0; j < DEPTH; j++) begin : g_ent
    logic wr_here;
    assign wr_here = ins && (base_cnt == CW'(j));
    always_ff @(posedge clk) begin
      if (wr_here) cur_q[j] <= acc_addr;
      if (copy) prev_q[j] <= wr_here ? acc_addr : cur_q[j];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cur_cnt   <= '0;
      prev_cnt  <= '0;
      drain_len <= '0;
      ptr       <= '0;
      have_prev <= 1'b0;
      ovf_q     <= 1'b0;
      mism_q    <= 1'b0;
    end else begin
      cur_cnt <= next_cnt;
      if (open_i)    ovf_q <= 1'b0;
      else if (drop) ovf_q <= 1'b1;
      if (close_i && have_prev) mism_q <= (next_cnt != prev_cnt);
      if (copy) begin
        prev_cnt  <= next_cnt;
        have_prev <= 1'b1;
      end
      if (close_i) begin
        ptr       <= '0;
        drain_len <= shorter;
      end else if ((st == S_DRAIN) && diff_ready) begin
        ptr <= ptr + ONE;
      end
      unique case (st)
        S_IDLE:  if (open_i) st <= S_ACT;
        S_ACT:   if (close_i) st <= go_drain ? S_DRAIN : S_IDLE;
        S_DRAIN: if (fin) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [IW-1:0] pi;
  assign pi           = ptr[IW-1:0];
  assign diff_valid   = (st == S_DRAIN);
  assign diff_last    = diff_valid && (ptr == drain_len - ONE);
  assign diff_data    = {1'b0, cur_q[pi]} - {1'b0, prev_q[pi]};
  assign cur_count    = cur_cnt;
  assign prev_count   = prev_cnt;
  assign overflow     = ovf_q;
  assign len_mismatch = mism_q;
  assign cur_rd_addr  = cur_q[rd_idx];
  assign prev_rd_addr = prev_q[rd_idx];

  logic unused_ok;
  assign unused_ok = acc_write;
endmodule

// File: rtl/tdiff_unit_chk.sv
module tdiff_unit_chk #(
  parameter int AW    = 32,
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       task_start,
  input logic                       diff_ready,
  input logic                       diff_valid,
  input logic [AW:0]                diff_data,
  input logic                       diff_last,
  input logic [$clog2(DEPTH+1)-1:0] cur_count,
  input logic [$clog2(DEPTH+1)-1:0] prev_count,
  input logic                       overflow
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] ONE  = CW'(1);

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    diff_valid && !diff_ready |=> diff_valid && $stable(diff_data) && $stable(diff_last)); // R8
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    diff_last |-> diff_valid); // R8
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cur_count <= FULL); // R4
  AST_OVF_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> cur_count == FULL); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !task_start |=> (cur_count == $past(cur_count)) || (cur_count == $past(cur_count) + ONE)); // R2
  AST_STREAM_NEEDS_PREV: assert property (@(posedge clk) disable iff (!rst_n)
    diff_valid |-> (prev_count != '0) && (cur_count != '0)); // R5
  AST_DRAIN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    diff_valid |=> $stable(cur_count)); // R9
endmodule

bind tdiff_unit tdiff_unit_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .task_start(task_start), .diff_ready(diff_ready),
  .diff_valid(diff_valid), .diff_data(diff_data), .diff_last(diff_last),
  .cur_count(cur_count), .prev_count(prev_count), .overflow(overflow)
);

// File: tb/tdiff_unit_test.sv
module tdiff_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DEPTH = 4;
  localparam int CW = $clog2(DEPTH+1);
  localparam int IW = $clog2(DEPTH);
  localparam int NINST = 48;

  logic clk = 0, rst_n = 0;
  logic task_start = 0, task_stop = 0, acc_valid = 0, acc_write = 0, diff_ready = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [IW-1:0] rd_idx = '0;
  logic diff_valid, diff_last, overflow, len_mismatch;
  logic [AW:0] diff_data;
  logic [CW-1:0] cur_count, prev_count;
  logic [AW-1:0] cur_rd_addr, prev_rd_addr;

  tdiff_unit #(.AW(AW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .task_start(task_start), .task_stop(task_stop),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .diff_ready(diff_ready), .diff_valid(diff_valid), .diff_data(diff_data),
    .diff_last(diff_last), .cur_count(cur_count), .prev_count(prev_count),
    .overflow(overflow), .len_mismatch(len_mismatch), .rd_idx(rd_idx),
    .cur_rd_addr(cur_rd_addr), .prev_rd_addr(prev_rd_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [AW-1:0] mcur [DEPTH];
  logic [AW-1:0] mprev[DEPTH];
  int ccnt = 0, pcnt = 0;
  bit have_prev = 0, movf = 0, mism = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] addr_of(int k, int i, int len);
    int j, base, step;
    j = (i < len) ? i : i - len;
    base = (k * 389) % 4096;
    if (k % 9 == 4) base = 0;
    if (k % 9 == 5) base = 4095;
    step = (k % 5) * 53 + 1;
    return AW'((base + j * step) % 4096);
  endfunction

  task automatic model_acc(logic [AW-1:0] a);
    bit found = 0;
    for (int j = 0; j < ccnt; j++) if (mcur[j] == a) found = 1;
    if (!found) begin
      if (ccnt < DEPTH) begin mcur[ccnt] = a; ccnt++; end
      else movf = 1;
    end
  endtask

  task automatic drive_acc(logic [AW-1:0] a, int i);
    acc_valid = 1; acc_addr = a; acc_write = i[0];
  endtask

  task automatic clear_in();
    task_start = 0; task_stop = 0; acc_valid = 0; acc_write = 0;
  endtask

  task automatic run_instance(int k);
    int len, nacc, n, e, g;
    bit sw, pw, pv, r, v, l;
    logic [AW:0] d, pd;
    logic pl;
    len = k % 7;
    nacc = len + ((len > 1) ? 2 : 0);
    sw = (k % 2 == 1) && (nacc > 0);
    pw = (k % 3 == 1) && (nacc > (sw ? 1 : 0));
    // open
    task_start = 1; ccnt = 0; movf = 0;
    if (sw) begin drive_acc(addr_of(k, 0, len), 0); model_acc(addr_of(k, 0, len)); end
    @(negedge clk); clear_in();
    for (int i = (sw ? 1 : 0); i < nacc - (pw ? 1 : 0); i++) begin
      if ((i + k) % 4 == 0) @(negedge clk);
      drive_acc(addr_of(k, i, len), i); model_acc(addr_of(k, i, len));
      @(negedge clk); clear_in();
    end
    // close, possibly with an access on the same cycle
    task_stop = 1;
    if (pw) begin drive_acc(addr_of(k, nacc-1, len), nacc-1); model_acc(addr_of(k, nacc-1, len)); end
    @(negedge clk); clear_in();
    n = 0;
    if (have_prev) begin
      n = (ccnt < pcnt) ? ccnt : pcnt;
      mism = (ccnt != pcnt);
    end
    chk(overflow == movf, "R4 overflow", overflow, movf);
    chk(len_mismatch == mism, "R7 len_mismatch", len_mismatch, mism);
    e = 0; g = 0; pv = 0; pd = '0; pl = 0;
    if (n == 0) begin
      diff_ready = 1;
      chk(diff_valid == 0, have_prev ? "R7 empty vector" : "R5 first instance", diff_valid, 0);
    end
    while (e < n && g < 200) begin
      v = diff_valid; d = diff_data; l = diff_last;
      if (pv) begin
        chk(v == 1, "R8 hold valid", v, 1);
        chk(d == pd, "R8 hold data", int'(d), int'(pd));
        chk(l == pl, "R8 hold last", l, pl);
      end
      chk(v == 1, "R8 valid during stream", v, 1);
      if (v) begin
        int got, exp;
        got = int'($signed(d));
        exp = int'(mcur[e]) - int'(mprev[e]);
        chk(got == exp, "R6 element", got, exp);
        chk(l == (e == n - 1), "R8 last marker", l, (e == n - 1));
      end
      r = (k % 5 == 0) || ((g + k) % 3 != 0);
      diff_ready = r;
      if (k % 4 == 0 && g == 1) begin
        task_start = 1; task_stop = 1; acc_valid = 1; acc_addr = 12'h123;
      end
      pv = v && !r; pd = d; pl = l;
      if (v && r) e++;
      @(negedge clk); clear_in(); g++;
    end
    chk(e == n, "R7 vector length", e, n);
    chk(diff_valid == 0, "R8 stream ends", diff_valid, 0);
    chk(cur_count == CW'(ccnt), "R9 current list frozen", cur_count, ccnt);
    chk(prev_count == CW'(ccnt), "R5 previous count", prev_count, ccnt);
    for (int i = 0; i < ccnt; i++) begin
      rd_idx = IW'(i); #1;
      chk(cur_rd_addr == mcur[i], "R3 current order", cur_rd_addr, mcur[i]);
      chk(prev_rd_addr == mcur[i], "R5 previous list", prev_rd_addr, mcur[i]);
    end
    for (int i = 0; i < DEPTH; i++) mprev[i] = mcur[i];
    pcnt = ccnt; have_prev = 1;
    diff_ready = 0;
    if (k % 3 == 2) begin
      acc_valid = 1; acc_addr = 12'h0AB; task_stop = 1;
      @(negedge clk); clear_in();
      @(negedge clk);
      chk(cur_count == CW'(ccnt), "R1 idle access ignored", cur_count, ccnt);
      chk(diff_valid == 0, "R1 idle stop ignored", diff_valid, 0);
      chk(prev_count == CW'(pcnt), "R1 idle stop keeps previous", prev_count, pcnt);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(cur_count == 0, "R10 cur_count", cur_count, 0);
    chk(prev_count == 0, "R10 prev_count", prev_count, 0);
    chk(diff_valid == 0, "R10 diff_valid", diff_valid, 0);
    chk(overflow == 0, "R10 overflow", overflow, 0);
    chk(len_mismatch == 0, "R10 len_mismatch", len_mismatch, 0);
    // R2 repeats: a dedicated instance with one address hit by read and write
    task_start = 1; drive_acc(12'h321, 0);
    @(negedge clk); clear_in();
    drive_acc(12'h321, 1); @(negedge clk); clear_in();
    drive_acc(12'h321, 0); @(negedge clk); clear_in();
    chk(cur_count == 1, "R2 repeat adds nothing", cur_count, 1);
    task_stop = 1; @(negedge clk); clear_in();
    chk(diff_valid == 0, "R5 first instance no vector", diff_valid, 0);
    mprev[0] = 12'h321; pcnt = 1; have_prev = 1; mcur[0] = 12'h321; ccnt = 1;
    for (int k = 0; k < NINST; k++) run_instance(k);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule